// File: doc/BRIEF.md
# Indexed Clock Register Port

This block is the host-facing register file of a real-time clock. It occupies two byte-wide addresses. A write to the even address selects one of the internal registers through a 7-bit index. An access to the odd address then reads or writes the selected register. Behind the port sit four control bytes, three alarm bytes, seven time bytes and plain byte storage.

The block enforces the access rules of the control bytes. The update-in-progress flag cannot be written by the host. Entering set mode clears that flag. The flag register is cleared when it is read, and the interrupt drops with it. The status byte is fixed. The time-keeping engine and the periodic-rate generator sit outside the block. The engine raises flags through a request vector, drives the update-in-progress flag, and writes fresh time bytes through its own port. A one-cycle load strobe tells it to take the host's time bytes over as the new time.

Register indices: 0x00 seconds, 0x02 minutes, 0x04 hours, 0x06 day of week, 0x07 day of month, 0x08 month, 0x09 year. The alarm bytes are 0x01, 0x03 and 0x05. Control A is 0x0A, control B is 0x0B, the flag register C is 0x0C and the status byte D is 0x0D. Indices from 0x0E up to REG_COUNT-1 are plain storage.

Top module: `rtc_index_port`

## Requirements
- R1: A write to the even address (bus_odd_i=0) stores bus_wdata_i[6:0] as the register index. Bit 7 of the data is dropped.
- R2: `bus_rdata_o` is 0xFF whenever bus_odd_i=0. It is also 0xFF when the index is REG_COUNT (64 by default) or higher. Otherwise it shows the selected register in the same cycle.
- R3: An odd-address write is ignored when the index is REG_COUNT or higher. Storage that the truncated index would reach stays unchanged.
- R4: Bit 7 of control A is the update-in-progress flag, and a host write cannot change it. A host write to control A stores bits 6:0. The flag clears on uip_clr_i and otherwise sets on uip_set_i. A clear wins over a set.
- R5: A host write to control B stores the whole byte. When bit 7 (set mode) of the written data is 1, the update-in-progress flag is cleared in the same update.
- R6: `time_load_o` pulses for one cycle, in the cycle after either of two host writes. The first is a write to a time byte while control B bit 7 is 0. The second is a write to control B with data bit 7 at 0 while B bit 7 is 1. No other access pulses it.
- R7: Host writes to C (0x0C) and D (0x0D) have no effect. D always reads 0x80.
- R8: An odd-address read with index 0x0C returns the current C. C then becomes 0x00, apart from requests in the same cycle. `irq_o` follows C bit 7, so it drops after the read.
- R9: After reset: A=0x26, B=0x02, C=0x00, D=0x80, index 0, and all storage bytes 0x00.
- R10: Bits of flag_set_i are ORed into C at each clock. A request that arrives in the same cycle as a read of C is kept in C after the read.
- R11: Alarm bytes and plain storage bytes (0x0E and up) read back exactly what the host last wrote.
- R12: An engine write (tk_we_i) to a time-byte index updates that byte. Engine writes to any other index are ignored. A host write to the same byte in the same cycle wins. `time_bytes_o` carries bytes 0x00 to 0x09, with byte i at bits 8i+7:8i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Host access valid this cycle |
| bus_odd_i | input | 1 | 0 selects the index address, 1 the data address |
| bus_wr_i | input | 1 | 1 write, 0 read |
| bus_wdata_i | input | 8 | Host write data |
| bus_rdata_o | output | 8 | Host read data |
| flag_set_i | input | 8 | Requests ORed into register C |
| uip_set_i | input | 1 | Engine sets update-in-progress |
| uip_clr_i | input | 1 | Engine clears update-in-progress |
| tk_we_i | input | 1 | Engine time-byte write enable |
| tk_idx_i | input | 4 | Engine time-byte index |
| tk_data_i | input | 8 | Engine time-byte data |
| ctrl_a_o | output | 8 | Control A contents |
| ctrl_b_o | output | 8 | Control B contents |
| time_bytes_o | output | 80 | Bytes 0x00 to 0x09 |
| time_load_o | output | 1 | One-cycle load strobe to the engine |
| irq_o | output | 1 | Interrupt request (C bit 7) |

## Verification
Errors in the index register or in a read-mux lane appear at `bus_rdata_o` on the next data-address read, in the same cycle. A wrong control A or B shows at once on `ctrl_a_o` and `ctrl_b_o`, which the bench compares every cycle. A flag register that fails to clear or to merge requests shows on `irq_o` one clock after the read or request. A mis-timed load strobe is visible exactly one cycle after the write that should or should not cause it.

// File: rtl/rtc_port_pkg.sv
package rtc_port_pkg;
  localparam int IDX_W = 7;
  localparam logic [3:0] IDX_A = 4'hA;
  localparam logic [3:0] IDX_B = 4'hB;
  localparam logic [3:0] IDX_C = 4'hC;
  localparam logic [3:0] IDX_D = 4'hD;
  localparam logic [7:0] RST_A = 8'h26;
  localparam logic [7:0] RST_B = 8'h02;
  localparam logic [7:0] RST_C = 8'h00;
  localparam logic [7:0] VAL_D = 8'h80;

  function automatic logic is_time_idx(input logic [IDX_W-1:0] idx);
    case (idx)
      7'h00, 7'h02, 7'h04, 7'h06, 7'h07, 7'h08, 7'h09: is_time_idx = 1'b1;
      default: is_time_idx = 1'b0;
    endcase
  endfunction

  function automatic logic is_ctrl_idx(input logic [IDX_W-1:0] idx);
    is_ctrl_idx = (idx >= 7'h0A) && (idx <= 7'h0D);
  endfunction
endpackage

// File: rtl/rtc_index_reg.sv
module rtc_index_reg
  import rtc_port_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [7:0]       data_i,
  output logic [IDX_W-1:0] idx_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     idx_o <= '0;
    else if (load_i) idx_o <= data_i[IDX_W-1:0];
  end
endmodule

// File: rtl/rtc_ctrl_regs.sv
module rtc_ctrl_regs
  import rtc_port_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_a_i,
  input  logic       wr_b_i,
  input  logic       rd_c_i,
  input  logic [7:0] wdata_i,
  input  logic [7:0] flag_set_i,
  input  logic       uip_set_i,
  input  logic       uip_clr_i,
  output logic [7:0] a_o,
  output logic [7:0] b_o,
  output logic [7:0] c_o
);
  logic       uip_q;
  logic [6:0] a_low_q;
  logic       uip_d;

  always_comb begin
    uip_d = uip_q;
    if ((wr_b_i && wdata_i[7]) || uip_clr_i) uip_d = 1'b0;
    else if (uip_set_i)                      uip_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      uip_q   <= RST_A[7];
      a_low_q <= RST_A[6:0];
      b_o     <= RST_B;
      c_o     <= RST_C;
    end else begin
      uip_q <= uip_d;
      if (wr_a_i) a_low_q <= wdata_i[6:0];
      if (wr_b_i) b_o <= wdata_i;
      // read clears, same-cycle requests survive
      c_o <= rd_c_i ? flag_set_i : (c_o | flag_set_i);
    end
  end

  assign a_o = {uip_q, a_low_q};
endmodule

// File: rtl/rtc_byte_store.sv
module rtc_byte_store
  import rtc_port_pkg::*;
#(
  parameter int REG_COUNT = 64
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   host_we_i,
  input  logic [IDX_W-1:0]       host_idx_i,
  input  logic [7:0]             host_data_i,
  input  logic                   tk_we_i,
  input  logic [3:0]             tk_idx_i,
  input  logic [7:0]             tk_data_i,
  output logic [REG_COUNT*8-1:0] mem_o
);
  logic [IDX_W-1:0] tk_idx_ext;
  logic             tk_ok;

  assign tk_idx_ext = {3'b000, tk_idx_i};
  assign tk_ok      = tk_we_i && is_time_idx(tk_idx_ext);

  for (genvar i = 0; i < REG_COUNT; i++) begin : g_byte
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);
    if (is_ctrl_idx(MY_IDX)) begin : g_hole
      assign mem_o[i*8 +: 8] = 8'h00;
    end else begin : g_cell
      logic [7:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                  q <= 8'h00;
        else if (host_we_i && host_idx_i == MY_IDX)   q <= host_data_i;
        else if (tk_ok && tk_idx_ext == MY_IDX)       q <= tk_data_i;
      end
      assign mem_o[i*8 +: 8] = q;
    end
  end
endmodule

// File: rtl/rtc_index_port.sv
module rtc_index_port
  import rtc_port_pkg::*;
#(
  parameter int REG_COUNT  = 64,
  parameter int TIME_BYTES = 10
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    bus_sel_i,
  input  logic                    bus_odd_i,
  input  logic                    bus_wr_i,
  input  logic [7:0]              bus_wdata_i,
  output logic [7:0]              bus_rdata_o,
  input  logic [7:0]              flag_set_i,
  input  logic                    uip_set_i,
  input  logic                    uip_clr_i,
  input  logic                    tk_we_i,
  input  logic [3:0]              tk_idx_i,
  input  logic [7:0]              tk_data_i,
  output logic [7:0]              ctrl_a_o,
  output logic [7:0]              ctrl_b_o,
  output logic [TIME_BYTES*8-1:0] time_bytes_o,
  output logic                    time_load_o
  ,output logic                   irq_o
);
  localparam int RI_W = $clog2(REG_COUNT);

  logic [IDX_W-1:0]       idx_q;
  logic                   in_range, odd_wr, odd_rd;
  logic                   wr_a, wr_b, rd_c, store_we, load_d;
  logic [7:0]             reg_c;
  logic [REG_COUNT*8-1:0] mem;
  logic [RI_W-1:0]        ridx;

  assign in_range = 32'(idx_q) < REG_COUNT;
  assign odd_wr   = bus_sel_i && bus_odd_i && bus_wr_i && in_range;
  assign odd_rd   = bus_sel_i && bus_odd_i && !bus_wr_i && in_range;
  assign wr_a     = odd_wr && idx_q == IDX_W'(IDX_A);
  assign wr_b     = odd_wr && idx_q == IDX_W'(IDX_B);
  assign rd_c     = odd_rd && idx_q == IDX_W'(IDX_C);
  assign store_we = odd_wr && !is_ctrl_idx(idx_q);
  assign load_d   = odd_wr && ((is_time_idx(idx_q) && !ctrl_b_o[7]) ||
                               (wr_b && !bus_wdata_i[7] && ctrl_b_o[7]));

  rtc_index_reg u_index (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (bus_sel_i && !bus_odd_i && bus_wr_i),
    .data_i (bus_wdata_i),
    .idx_o  (idx_q)
  );

  rtc_ctrl_regs u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_a_i     (wr_a),
    .wr_b_i     (wr_b),
    .rd_c_i     (rd_c),
    .wdata_i    (bus_wdata_i),
    .flag_set_i (flag_set_i),
    .uip_set_i  (uip_set_i),
    .uip_clr_i  (uip_clr_i),
    .a_o        (ctrl_a_o),
    .b_o        (ctrl_b_o),
    .c_o        (reg_c)
  );

  rtc_byte_store #(.REG_COUNT(REG_COUNT)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .host_we_i   (store_we),
    .host_idx_i  (idx_q),
    .host_data_i (bus_wdata_i),
    .tk_we_i     (tk_we_i),
    .tk_idx_i    (tk_idx_i),
    .tk_data_i   (tk_data_i),
    .mem_o       (mem)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) time_load_o <= 1'b0;
    else         time_load_o <= load_d;
  end

  assign ridx = idx_q[RI_W-1:0];

  always_comb begin
    if (!bus_odd_i || !in_range) bus_rdata_o = 8'hFF;
    else begin
      case (idx_q)
        IDX_W'(IDX_A): bus_rdata_o = ctrl_a_o;
        IDX_W'(IDX_B): bus_rdata_o = ctrl_b_o;
        IDX_W'(IDX_C): bus_rdata_o = reg_c;
        IDX_W'(IDX_D): bus_rdata_o = VAL_D;
        default:       bus_rdata_o = mem[ridx*8 +: 8];
      endcase
    end
  end

  assign time_bytes_o = mem[TIME_BYTES*8-1:0];
  assign irq_o        = reg_c[7];
endmodule

// File: rtl/rtc_index_port_chk.sv
module rtc_index_port_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bus_sel_i,
  input logic       bus_odd_i,
  input logic       bus_wr_i,
  input logic [7:0] bus_wdata_i,
  input logic [7:0] bus_rdata_o,
  input logic [7:0] flag_set_i,
  input logic       uip_set_i,
  input logic       uip_clr_i,
  input logic [7:0] ctrl_a_o,
  input logic [7:0] ctrl_b_o,
  input logic       time_load_o,
  input logic       irq_o,
  input logic [6:0] idx_q
);
  logic odd_wr_c;
  assign odd_wr_c = bus_sel_i && bus_odd_i && bus_wr_i;

  p_even_ff_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_odd_i |-> bus_rdata_o == 8'hFF);

  p_uip_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (odd_wr_c && idx_q == 7'h0A && !uip_set_i && !uip_clr_i)
      |=> ctrl_a_o[7] == $past(ctrl_a_o[7]));

  p_set_clr_uip_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (odd_wr_c && idx_q == 7'h0B && bus_wdata_i[7]) |=> !ctrl_a_o[7]);

  p_time_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (odd_wr_c && idx_q == 7'h02 && !ctrl_b_o[7]) |=> time_load_o);

  p_irq_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_sel_i && bus_odd_i && !bus_wr_i && idx_q == 7'h0C && flag_set_i == 8'h00)
      |=> !irq_o);

  p_flag_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_set_i[7] |=> irq_o);
endmodule

bind rtc_index_port rtc_index_port_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_sel_i   (bus_sel_i),
  .bus_odd_i   (bus_odd_i),
  .bus_wr_i    (bus_wr_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .flag_set_i  (flag_set_i),
  .uip_set_i   (uip_set_i),
  .uip_clr_i   (uip_clr_i),
  .ctrl_a_o    (ctrl_a_o),
  .ctrl_b_o    (ctrl_b_o),
  .time_load_o (time_load_o),
  .irq_o       (irq_o),
  .idx_q       (idx_q)
);

// File: tb/rtc_index_port_tb.sv
module rtc_index_port_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_sel_i = 0, bus_odd_i = 0, bus_wr_i = 0;
  logic [7:0]  bus_wdata_i = 0, bus_rdata_o;
  logic [7:0]  flag_set_i = 0;
  logic        uip_set_i = 0, uip_clr_i = 0, tk_we_i = 0;
  logic [3:0]  tk_idx_i = 0;
  logic [7:0]  tk_data_i = 0;
  logic [7:0]  ctrl_a_o, ctrl_b_o;
  logic [79:0] time_bytes_o;
  logic        time_load_o, irq_o;

  int n_chk = 0, n_bad = 0;
  logic [7:0] m [0:63];
  logic [6:0] idx_m;
  logic       ld_m;

  always #5 clk_i = ~clk_i;

  rtc_index_port u_dut (.*);

  task automatic chk(string req, logic [79:0] act, logic [79:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic is_time(logic [6:0] i);
    return i == 0 || i == 2 || i == 4 || i == 6 || i == 7 || i == 8 || i == 9;
  endfunction

  function automatic logic [7:0] exp_rd(logic odd);
    if (!odd || idx_m >= 64) return 8'hFF;
    return m[idx_m];
  endfunction

  function automatic logic [79:0] exp_tb();
    logic [79:0] v;
    for (int i = 0; i < 10; i++) v[i*8 +: 8] = m[i];
    return v;
  endfunction

  task automatic reset_model();
    for (int i = 0; i < 64; i++) m[i] = 8'h00;
    m[10] = 8'h26; m[11] = 8'h02; m[12] = 8'h00; m[13] = 8'h80;
    idx_m = 0; ld_m = 0;
  endtask

  // one clock; drive, check, update model
  task automatic cyc(string req, logic sel, logic odd, logic wr, logic [7:0] wd,
                     logic [7:0] fs = 0, logic us = 0, logic uc = 0,
                     logic tkw = 0, logic [3:0] tki = 0, logic [7:0] tkd = 0);
    logic [7:0] n [0:63];
    logic hw, rdc;
    bus_sel_i = sel; bus_odd_i = odd; bus_wr_i = wr; bus_wdata_i = wd;
    flag_set_i = fs; uip_set_i = us; uip_clr_i = uc;
    tk_we_i = tkw; tk_idx_i = tki; tk_data_i = tkd;
    #1;
    chk(req, 80'(bus_rdata_o), 80'(exp_rd(odd)));
    chk("R4 ctrl_a", 80'(ctrl_a_o), 80'(m[10]));
    chk("R5 ctrl_b", 80'(ctrl_b_o), 80'(m[11]));
    chk("R8 irq", 80'(irq_o), 80'(m[12][7]));
    chk("R6 time_load", 80'(time_load_o), 80'(ld_m));
    chk("R12 time_bytes", time_bytes_o, exp_tb());
    n = m;
    hw  = sel && odd && wr && idx_m < 64;
    rdc = sel && odd && !wr && idx_m == 12;
    ld_m = hw && ((is_time(idx_m) && !m[11][7]) || (idx_m == 11 && !wd[7] && m[11][7]));
    if (tkw && is_time({3'b0, tki})) n[tki] = tkd;
    if (hw) begin
      case (idx_m)
        10: n[10][6:0] = wd[6:0];
        11: n[11] = wd;
        12, 13: ;
        default: n[idx_m[5:0]] = wd;
      endcase
    end
    if ((hw && idx_m == 11 && wd[7]) || uc) n[10][7] = 1'b0;
    else if (us) n[10][7] = 1'b1;
    n[12] = rdc ? fs : (m[12] | fs);
    if (sel && !odd && wr) idx_m = wd[6:0];
    m = n;
    @(posedge clk_i); @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    reset_model();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R9 reset state
    cyc("R9 reset idx0", 1, 1, 0, 0);
    cyc("R9", 1, 0, 1, 8'h0A); cyc("R9 reset A", 1, 1, 0, 0);
    cyc("R9", 1, 0, 1, 8'h0B); cyc("R9 reset B", 1, 1, 0, 0);
    cyc("R9", 1, 0, 1, 8'h0D); cyc("R9 reset D", 1, 1, 0, 0);
    // R1 index masked: 0x8C -> 0x0C
    cyc("R1", 1, 0, 1, 8'h8C); cyc("R1 masked index reads C", 1, 1, 0, 0);
    // R2 even read
    cyc("R2 even read", 1, 0, 0, 0);
    // R7 C/D ignore writes
    cyc("R7", 1, 1, 1, 8'hFF); cyc("R7 C unchanged", 1, 1, 0, 0);
    cyc("R7", 1, 0, 1, 8'h0D); cyc("R7", 1, 1, 1, 8'h00); cyc("R7 D unchanged", 1, 1, 0, 0);
    // R4 UIP read-only
    cyc("R4", 1, 0, 1, 8'h0A, 0, 1); cyc("R4", 1, 1, 1, 8'h05); cyc("R4 uip kept", 1, 1, 0, 0);
    cyc("R4", 1, 1, 1, 8'hFF, 0, 1, 1); cyc("R4 clr wins", 1, 1, 0, 0);
    // R5 set mode clears UIP; R6 leaving set mode loads
    cyc("R5", 1, 1, 0, 0, 0, 1);
    cyc("R5", 1, 0, 1, 8'h0B); cyc("R5", 1, 1, 1, 8'h82); cyc("R5 uip cleared", 1, 1, 0, 0);
    cyc("R6", 1, 0, 1, 8'h02); cyc("R6", 1, 1, 1, 8'h59); cyc("R6 no load in set mode", 0, 1, 0, 0);
    cyc("R6", 1, 0, 1, 8'h0B); cyc("R6", 1, 1, 1, 8'h02); cyc("R6 load on exit", 0, 1, 0, 0);
    cyc("R6", 1, 0, 1, 8'h04); cyc("R6", 1, 1, 1, 8'h23); cyc("R6 load on time write", 0, 1, 0, 0);
    // R10 set with read-clear wins; R8 clear
    cyc("R10", 1, 0, 1, 8'h0C, 8'h10); cyc("R10", 1, 1, 0, 0, 8'h80);
    cyc("R10 flag survives read", 1, 1, 0, 0); cyc("R8 cleared", 1, 1, 0, 0);
    // R3 out-of-range write ignored (0x50 would alias 0x10)
    cyc("R11", 1, 0, 1, 8'h10); cyc("R11", 1, 1, 1, 8'hA5);
    cyc("R3", 1, 0, 1, 8'h50); cyc("R3", 1, 1, 1, 8'h3C); cyc("R2 out of range reads FF", 1, 1, 0, 0);
    cyc("R3", 1, 0, 1, 8'h10); cyc("R3 storage unchanged", 1, 1, 0, 0);
    // R12 engine write, conflict with host
    cyc("R12", 1, 0, 1, 8'h07, 0, 0, 0, 1, 4'h8, 8'h11);
    cyc("R12", 1, 1, 1, 8'h31, 0, 0, 0, 1, 4'h7, 8'h15);
    cyc("R12 host wins", 1, 1, 0, 0, 0, 0, 0, 1, 4'h3, 8'hEE);
    cyc("R11", 1, 0, 1, 8'h03); cyc("R12 alarm not engine-writable", 1, 1, 0, 0);
    // random
    for (int k = 0; k < 4000; k++) begin
      int r;
      logic [7:0] d, ix;
      r = $urandom_range(0, 9);
      d = 8'($urandom);
      ix = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'($urandom_range(0, 15));
      case (r)
        0, 1: cyc("R1", 1, 0, 1, ix);
        2, 3, 4: cyc("R11", 1, 1, 1, d, ($urandom_range(0, 7) == 0) ? 8'($urandom) : 8'h00,
                      $urandom_range(0, 5) == 0, $urandom_range(0, 5) == 0,
                      $urandom_range(0, 1) == 1, 4'($urandom), 8'($urandom));
        5, 6, 7: cyc("R2", 1, 1, 0, d, ($urandom_range(0, 5) == 0) ? 8'($urandom) : 8'h00,
                      $urandom_range(0, 5) == 0, $urandom_range(0, 5) == 0);
        8: cyc("R2", 1, 0, 0, d);
        default: cyc("R10", 0, $urandom_range(0, 1) == 1, 1, d, 8'($urandom),
                      1, 0, 1, 4'($urandom), 8'($urandom));
      endcase
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule